// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the scan timing for a progressive raster display from one pixel clock. A horizontal position counter steps once per clock. A line counter steps once per completed line. Both positions are decoded into a horizontal sync, a vertical sync and a blanking flag. The same positions also drive a simple 8-bit-per-channel colour test pattern. The block feeds a downstream encoder and serializer, which are not part of it.

Every boundary is a parameter: the visible extent, the sync start, the sync end and the total count of each axis. The active level of each sync is also a parameter, set separately per axis. The defaults describe a 640×480 frame refreshed at 60 Hz from a 25 MHz pixel clock, with an active-low horizontal sync and an active-high vertical sync. All outputs leave the block from registers, so they stay mutually aligned.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal position counts 0, 1, … H_TOTAL-1 on successive clocks and then returns to 0 (default H_TOTAL = 800).
- R2: The vertical position changes only in the clock where the horizontal position returns to 0. It then steps by one and returns from V_TOTAL-1 to 0 (default V_TOTAL = 525).
- R3: `blank` is 1 exactly when the horizontal position is at least H_VISIBLE or the vertical position is at least V_VISIBLE (defaults 640 and 480).
- R4: `hsync` is at level H_SYNC_ACT for horizontal positions h with H_SYNC_START <= h < H_SYNC_END, and at the opposite level otherwise. The defaults are a 656 to 752 window with level 0.
- R5: `vsync` is at level V_SYNC_ACT for vertical positions v with V_SYNC_START <= v < V_SYNC_END, and at the opposite level otherwise. The defaults are a 490 to 492 window with level 1.
- R6: While not blanked, `red` equals h mod 256 and `green` equals v mod 256. `blue` equals F(h) XOR F(v), where F(x) is the XOR of all 8-bit chunks of x, taken from bit 0 upward. While `blank` is 1, all three colour outputs are 0.
- R7: Every output presents the decode of the position held one clock earlier. The first clock after reset is released shows position (0,0), and all outputs change in the same clock.
- R8: A synchronous active-high `rst` returns both positions to 0. While it is held, both syncs sit at their inactive levels, `blank` is 1 and the colour outputs are 0. This holds even when reset is applied in the middle of a frame.
- R9: The two sync polarities are independent. Inverting H_SYNC_ACT and V_SYNC_ACT inverts `hsync` and `vsync` and changes no other output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| red | output | 8 | Test pattern red channel |
| green | output | 8 | Test pattern green channel |
| blue | output | 8 | Test pattern blue channel |
| hsync | output | 1 | Horizontal sync at the configured level |
| vsync | output | 1 | Vertical sync at the configured level |
| blank | output | 1 | High outside the visible area |

## Verification
The assertions assume that `rst` is held for at least one clock at start-up. They also assume the parameters are ordered, with visible count <= sync start <= sync end <= total on each axis. Without that, the window and wrap checks have no meaning. The bench keeps every instance within these limits. It uses one shrunken, ordered geometry that fits two full frames into a few hundred clocks, in both sync polarities, plus the default geometry over its first lines. It changes `rst` only at falling clock edges.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam rgb_t RGB_BLACK = '{r: 8'h00, g: 8'h00, b: 8'h00};

endpackage

// File: rtl/vtg_axis_counter.sv
module vtg_axis_counter #(
  parameter int TOTAL = 800,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         last
);

  localparam logic [W-1:0] LAST_C = W'(TOTAL - 1);

  assign last = (cnt == LAST_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_C);

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == LAST_C) |=> cnt == '0);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt != LAST_C) |=> cnt == W'($past(cnt) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));

endmodule

// File: rtl/vtg_axis_window.sv
module vtg_axis_window #(
  parameter int W          = 10,
  parameter int VISIBLE    = 640,
  parameter int SYNC_START = 656,
  parameter int SYNC_END   = 752
) (
  input  logic [W-1:0] cnt,
  output logic         in_view,
  output logic         in_sync
);

  localparam logic [W-1:0] VIS_C = W'(VISIBLE);
  localparam logic [W-1:0] SS_C  = W'(SYNC_START);
  localparam logic [W-1:0] SE_C  = W'(SYNC_END);

  always_comb begin
    in_view = (cnt < VIS_C);
    in_sync = (cnt >= SS_C) && (cnt < SE_C);
  end

endmodule

// File: rtl/vtg_pattern.sv
module vtg_pattern
  import vtg_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  output rgb_t          pix
);

  localparam int HCH = (HW + 7) / 8;
  localparam int VCH = (VW + 7) / 8;

  logic [HCH*8-1:0] h_pad;
  logic [VCH*8-1:0] v_pad;
  logic [7:0]       h_fold;
  logic [7:0]       v_fold;

  assign h_pad = (HCH*8)'(h);
  assign v_pad = (VCH*8)'(v);

  always_comb begin
    h_fold = '0;
    for (int i = 0; i < HCH; i++) h_fold ^= h_pad[8*i +: 8];
    v_fold = '0;
    for (int i = 0; i < VCH; i++) v_fold ^= v_pad[8*i +: 8];
  end

  always_comb begin
    pix.r = h_pad[7:0];
    pix.g = v_pad[7:0];
    pix.b = h_fold ^ v_fold;
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import vtg_pkg::*;
#(
  parameter int H_VISIBLE    = 640,
  parameter int H_SYNC_START = 656,
  parameter int H_SYNC_END   = 752,
  parameter int H_TOTAL      = 800,
  parameter bit H_SYNC_ACT   = 1'b0,
  parameter int V_VISIBLE    = 480,
  parameter int V_SYNC_START = 490,
  parameter int V_SYNC_END   = 492,
  parameter int V_TOTAL      = 525,
  parameter bit V_SYNC_ACT   = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] red,
  output logic [7:0] green,
  output logic [7:0] blue,
  output logic       hsync,
  output logic       vsync,
  output logic       blank
);

  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] HSS_C = HW'(H_SYNC_START);
  localparam logic [HW-1:0] HSE_C = HW'(H_SYNC_END);
  localparam logic [HW-1:0] HVIS_C = HW'(H_VISIBLE);
  localparam logic [VW-1:0] VVIS_C = VW'(V_VISIBLE);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_last;
  logic          v_last_unused;
  logic          h_view, v_view, h_sync_c, v_sync_c, blank_c;
  rgb_t          pat;

  vtg_axis_counter #(.TOTAL(H_TOTAL), .W(HW)) u_hcnt (
    .clk(clk), .rst(rst), .en(1'b1), .cnt(h_cnt), .last(h_last)
  );

  vtg_axis_counter #(.TOTAL(V_TOTAL), .W(VW)) u_vcnt (
    .clk(clk), .rst(rst), .en(h_last), .cnt(v_cnt), .last(v_last_unused)
  );

  vtg_axis_window #(
    .W(HW), .VISIBLE(H_VISIBLE), .SYNC_START(H_SYNC_START), .SYNC_END(H_SYNC_END)
  ) u_hwin (.cnt(h_cnt), .in_view(h_view), .in_sync(h_sync_c));

  vtg_axis_window #(
    .W(VW), .VISIBLE(V_VISIBLE), .SYNC_START(V_SYNC_START), .SYNC_END(V_SYNC_END)
  ) u_vwin (.cnt(v_cnt), .in_view(v_view), .in_sync(v_sync_c));

  vtg_pattern #(.HW(HW), .VW(VW)) u_pat (.h(h_cnt), .v(v_cnt), .pix(pat));

  assign blank_c = !(h_view && v_view);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= ~H_SYNC_ACT;
      vsync <= ~V_SYNC_ACT;
      blank <= 1'b1;
      {red, green, blue} <= RGB_BLACK;
    end else begin
      hsync <= h_sync_c ? H_SYNC_ACT : ~H_SYNC_ACT;
      vsync <= v_sync_c ? V_SYNC_ACT : ~V_SYNC_ACT;
      blank <= blank_c;
      {red, green, blue} <= blank_c ? RGB_BLACK : pat;
    end
  end

  // R6
  blank_black_chk: assert property (@(posedge clk) disable iff (rst)
    blank |-> (red == 8'h00 && green == 8'h00 && blue == 8'h00));

  // R3
  view_pos_chk: assert property (@(posedge clk) disable iff (rst)
    !blank |-> ($past(h_cnt) < HVIS_C && $past(v_cnt) < VVIS_C));

  // R4
  hsync_window_chk: assert property (@(posedge clk) disable iff (rst)
    (hsync == H_SYNC_ACT) |-> ($past(h_cnt) >= HSS_C && $past(h_cnt) < HSE_C));

  // R2
  vstep_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (v_cnt != $past(v_cnt)) |-> h_cnt == '0);

endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;

  localparam int SH_VIS = 16, SH_SS = 18, SH_SE = 21, SH_TOT = 24;
  localparam int SV_VIS = 8,  SV_SS = 9,  SV_SE = 10, SV_TOT = 12;
  localparam int DH_VIS = 640, DH_SS = 656, DH_SE = 752, DH_TOT = 800;
  localparam int DV_VIS = 480, DV_SS = 490, DV_SE = 492, DV_TOT = 525;

  // columns: h, v, expected hsync, vsync, blank (small geometry, default polarity)
  localparam int NTAB = 17;
  localparam int TAB [0:NTAB-1][0:4] = '{
    '{0, 0, 1, 0, 0},  '{15, 0, 1, 0, 0}, '{16, 0, 1, 0, 1},
    '{17, 0, 1, 0, 1}, '{18, 0, 0, 0, 1}, '{20, 0, 0, 0, 1},
    '{21, 0, 1, 0, 1}, '{23, 0, 1, 0, 1}, '{0, 1, 1, 0, 0},
    '{15, 7, 1, 0, 0}, '{0, 8, 1, 0, 1},  '{0, 9, 1, 1, 1},
    '{18, 9, 0, 1, 1}, '{23, 9, 1, 1, 1}, '{0, 10, 1, 0, 1},
    '{23, 11, 1, 0, 1}, '{0, 0, 1, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [7:0] s_r, s_g, s_b, i_r, i_g, i_b, d_r, d_g, d_b;
  logic s_hs, s_vs, s_bl, i_hs, i_vs, i_bl, d_hs, d_vs, d_bl;

  raster_timing_gen #(
    .H_VISIBLE(SH_VIS), .H_SYNC_START(SH_SS), .H_SYNC_END(SH_SE), .H_TOTAL(SH_TOT), .H_SYNC_ACT(1'b0),
    .V_VISIBLE(SV_VIS), .V_SYNC_START(SV_SS), .V_SYNC_END(SV_SE), .V_TOTAL(SV_TOT), .V_SYNC_ACT(1'b1)
  ) dut (.clk(clk), .rst(rst), .red(s_r), .green(s_g), .blue(s_b),
         .hsync(s_hs), .vsync(s_vs), .blank(s_bl));

  raster_timing_gen #(
    .H_VISIBLE(SH_VIS), .H_SYNC_START(SH_SS), .H_SYNC_END(SH_SE), .H_TOTAL(SH_TOT), .H_SYNC_ACT(1'b1),
    .V_VISIBLE(SV_VIS), .V_SYNC_START(SV_SS), .V_SYNC_END(SV_SE), .V_TOTAL(SV_TOT), .V_SYNC_ACT(1'b0)
  ) dut_inv (.clk(clk), .rst(rst), .red(i_r), .green(i_g), .blue(i_b),
             .hsync(i_hs), .vsync(i_vs), .blank(i_bl));

  raster_timing_gen dut_std (.clk(clk), .rst(rst), .red(d_r), .green(d_g), .blue(d_b),
                             .hsync(d_hs), .vsync(d_vs), .blank(d_bl));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int sh = 0, sv = 0, dh = 0, dv = 0;

  function automatic int fold8(int x);
    return (x ^ (x >> 8) ^ (x >> 16) ^ (x >> 24)) & 255;
  endfunction

  // {hsync, vsync, blank, red, green, blue}
  function automatic logic [26:0] model(int h, int v, int hv, int hs0, int hs1,
                                        int vv, int vs0, int vs1, bit ha, bit va);
    logic bl, hs, vs;
    logic [7:0] r, g, b;
    bl = (h >= hv) || (v >= vv);
    hs = (h >= hs0 && h < hs1) ? ha : ~ha;
    vs = (v >= vs0 && v < vs1) ? va : ~va;
    r = bl ? 8'd0 : 8'(h & 255);
    g = bl ? 8'd0 : 8'(v & 255);
    b = bl ? 8'd0 : 8'(fold8(h) ^ fold8(v));
    return {hs, vs, bl, r, g, b};
  endfunction

  task automatic check(string req, logic [26:0] act, logic [26:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (sh=%0d sv=%0d dh=%0d dv=%0d)",
               req, act, exp, sh, sv, dh, dv);
    end
  endtask

  // one clock: sample at the falling edge, compare all instances with the model
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    // R1 R2 R3 R4 R5 R6 R7
    check("R7", {s_hs, s_vs, s_bl, s_r, s_g, s_b},
          model(sh, sv, SH_VIS, SH_SS, SH_SE, SV_VIS, SV_SS, SV_SE, 1'b0, 1'b1));
    // R9: inverted polarity changes only the syncs
    check("R9", {i_hs, i_vs, i_bl, i_r, i_g, i_b},
          model(sh, sv, SH_VIS, SH_SS, SH_SE, SV_VIS, SV_SS, SV_SE, 1'b1, 1'b0));
    // R4 default geometry
    check("R4", {d_hs, d_vs, d_bl, d_r, d_g, d_b},
          model(dh, dv, DH_VIS, DH_SS, DH_SE, DV_VIS, DV_SS, DV_SE, 1'b0, 1'b1));
  endtask

  task automatic advance();
    if (sh == SH_TOT - 1) begin sh = 0; sv = (sv == SV_TOT - 1) ? 0 : sv + 1; end
    else sh++;
    if (dh == DH_TOT - 1) begin dh = 0; dv = (dv == DV_TOT - 1) ? 0 : dv + 1; end
    else dh++;
  endtask

  task automatic check_reset_state(string req);
    check(req, {s_hs, s_vs, s_bl, s_r, s_g, s_b}, {1'b1, 1'b0, 1'b1, 24'd0});
    check(req, {i_hs, i_vs, i_bl, i_r, i_g, i_b}, {1'b0, 1'b1, 1'b1, 24'd0});
    check(req, {d_hs, d_vs, d_bl, d_r, d_g, d_b}, {1'b1, 1'b0, 1'b1, 24'd0});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R8");
    rst = 1'b0;

    // table walk over hand-picked corners of the small geometry
    for (int k = 0; k < NTAB; k++) begin
      int guard = 0;
      while (!(sh == TAB[k][0] && sv == TAB[k][1]) && guard < 400) begin
        cycle();
        advance();
        guard++;
      end
      cycle();
      // R3 R4 R5: hand values at the listed position
      check("R5", {29'd0, s_hs, s_vs, s_bl},
            {29'd0, TAB[k][2] != 0, TAB[k][3] != 0, TAB[k][4] != 0});
      // R9: inverted instance shows the opposite sync levels
      check("R9", {29'd0, i_hs, i_vs, i_bl},
            {29'd0, TAB[k][2] == 0, TAB[k][3] == 0, TAB[k][4] != 0});
      advance();
    end

    // carry on through the first lines of the default geometry (R1 R2)
    while (dv < 2 || dh < 100) begin
      cycle();
      advance();
    end

    // mid-frame synchronous reset
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state("R8");
    @(posedge clk);
    @(negedge clk);
    check_reset_state("R8");
    rst = 1'b0;
    sh = 0; sv = 0; dh = 0; dv = 0;
    for (int n = 0; n < 60; n++) begin
      cycle();
      advance();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule